// File: doc/BRIEF.md
# Atomic read-modify-write memory unit

This unit carries out one indivisible read-modify-write on a single synchronous memory port for a processor. A request carries an operation code, a size flag, a byte address, a second operand and a compare value. The compare value is normally the contents of a special register. The unit reads the addressed memory word and derives a new value from it. It stores that value only when the operation's condition allows. It then returns the value that memory held before the operation, together with a flag that says whether a store happened.

For the whole sequence the unit holds a lock output high, and every memory cycle it issues falls inside that window. A processor or an arbiter can therefore treat the read, the decision and the store as one atomic step. A request whose address is not naturally aligned to its access size is refused with a fault pulse and causes no memory cycle.

The memory is 64 bits wide and word-addressed. A 4-byte access uses the half of the word that byte-address bit 2 selects. It sign-extends that half to 64 bits, and it stores only that half, using byte enables.

Top module: `atomic_rmw_unit`

## Requirements
- R1: On the done pulse, `done_old` equals the memory value as it stood before the operation, whether or not a store followed; for a 4-byte access this is the selected 32-bit half sign-extended to 64 bits.
- R2: Operation code 0 (exchange) always stores the second operand and reports `done_written`=1.
- R3: Operation code 1 (compare-exchange) stores the second operand only when the old value equals the compare value; in the 4-byte form the compare value's low 32 bits are sign-extended before the comparison; otherwise memory is unchanged and `done_written`=0.
- R4: Operation codes 2, 4 and 5 store old+operand, old AND operand and old OR operand respectively, always with `done_written`=1.
- R5: Operation code 3 stores old+operand only when that sum is not negative, the sign being bit 63 of the sum in the 8-byte form and bit 31 in the 4-byte form; a negative sum leaves memory unchanged and `done_written`=0.
- R6: With `req_size4`=1, address bit 2 = 0 selects bytes 0 to 3 (bits 31:0) of the memory word and bit 2 = 1 selects bytes 4 to 7 (bits 63:32); a store enables only those four bytes, carries the low 32 bits of the result and leaves the other half unchanged.
- R7: An address with a nonzero bit among bits 2:0 (8-byte form) or bits 1:0 (4-byte form) gives a one-cycle `fault` pulse in the cycle after the request. It starts no memory cycle, does not raise `busy` and gives no done pulse.
- R8: `busy` is high from the cycle after an accepted request up to and including the done cycle; the memory port is active only while `busy` is high; a request presented while `busy` is high is ignored.
- R9: `done` is a one-cycle pulse in the fourth cycle after the accepting clock edge when no store occurs, and in the fifth when a store occurs.
- R10: Operation codes 6 and 7 only read: memory is unchanged, `done_written`=0 and the old value is returned.
- R11: After reset `busy`, `done`, `fault` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_op | input | 3 | Operation code (0 exchange, 1 compare-exchange, 2 add, 3 add-if-not-negative, 4 AND, 5 OR) |
| req_size4 | input | 1 | 1 = 4-byte access, 0 = 8-byte access |
| req_addr | input | ADDR_W | Byte address |
| req_opnd | input | 64 | Second operand |
| req_cmp | input | 64 | Compare value from the special register |
| busy | output | 1 | Lock held for the whole sequence |
| done | output | 1 | One-cycle completion pulse |
| done_old | output | 64 | Old memory value, valid with done |
| done_written | output | 1 | A store took place, valid with done |
| fault | output | 1 | One-cycle misaligned-address pulse |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W-3 | Memory word address |
| mem_be | output | 8 | Byte enables for a store |
| mem_wdata | output | 64 | Store data |
| mem_rdata | input | 64 | Read data, one cycle after a read cycle |

## Verification
The bench builds the unit with ADDR_W set to 8, so the word address has five bits. A 32-word memory model behind the port then covers every address the vectors use, and the bench can inspect each word directly after an operation. The width still keeps bit 2 and the two alignment bit groups, so both halves of a word and both misalignment rules are reached. Operands are chosen so that the 4-byte and 8-byte interpretations disagree: sign-extended halves, a sum whose bit 31 and bit 63 differ, and compare values that match only after sign extension.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int XLEN       = 64;
  localparam int HALF       = XLEN / 2;
  localparam int BE_W       = XLEN / 8;
  localparam int HALF_BYTES = BE_W / 2;
  localparam int OP_W       = 3;

  typedef enum logic [OP_W-1:0] {
    AMO_XCHG   = 3'd0,
    AMO_CMPX   = 3'd1,
    AMO_ADD    = 3'd2,
    AMO_ADDGEZ = 3'd3,
    AMO_AND    = 3'd4,
    AMO_OR     = 3'd5
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WT   = 3'd2,
    ST_CMP  = 3'd3,
    ST_WR   = 3'd4,
    ST_DN   = 3'd5
  } amo_state_e;
endpackage

// File: rtl/amo_lane.sv
module amo_lane
  import amo_pkg::*;
(
  input  logic [XLEN-1:0] rd_word,
  input  logic            hi,
  input  logic            size4,
  input  logic [XLEN-1:0] new_val,
  output logic [XLEN-1:0] old_ext,
  output logic [XLEN-1:0] wr_word,
  output logic [BE_W-1:0] wr_be
);
  logic [HALF-1:0] half_sel;

  always_comb begin
    half_sel = hi ? rd_word[XLEN-1:HALF] : rd_word[HALF-1:0];
    old_ext  = size4 ? {{HALF{half_sel[HALF-1]}}, half_sel} : rd_word;
    wr_word  = size4 ? {2{new_val[HALF-1:0]}} : new_val;
  end

  for (genvar g = 0; g < BE_W; g++) begin : g_be
    localparam logic UPPER = (g >= HALF_BYTES);
    assign wr_be[g] = !size4 || (hi == UPPER);
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
(
  input  amo_op_e         op,
  input  logic            size4,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] opnd,
  input  logic [XLEN-1:0] cmp,
  output logic [XLEN-1:0] new_val,
  output logic            do_write
);
  logic [XLEN-1:0] cmp_ext;
  logic [XLEN-1:0] sum;
  logic            sum_neg;

  always_comb begin
    cmp_ext = size4 ? {{HALF{cmp[HALF-1]}}, cmp[HALF-1:0]} : cmp;
    sum     = old_val + opnd;
    sum_neg = size4 ? sum[HALF-1] : sum[XLEN-1];
    case (op)
      AMO_XCHG:   begin new_val = opnd;           do_write = 1'b1;                 end
      AMO_CMPX:   begin new_val = opnd;           do_write = (old_val == cmp_ext); end
      AMO_ADD:    begin new_val = sum;            do_write = 1'b1;                 end
      AMO_ADDGEZ: begin new_val = sum;            do_write = !sum_neg;             end
      AMO_AND:    begin new_val = old_val & opnd; do_write = 1'b1;                 end
      AMO_OR:     begin new_val = old_val | opnd; do_write = 1'b1;                 end
      default:    begin new_val = old_val;        do_write = 1'b0;                 end
    endcase
  end
endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [OP_W-1:0]   req_op,
  input  logic              req_size4,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [XLEN-1:0]   req_opnd,
  input  logic [XLEN-1:0]   req_cmp,
  input  logic [XLEN-1:0]   rd_ext,
  input  logic [XLEN-1:0]   alu_new,
  input  logic              alu_wr,
  input  logic [XLEN-1:0]   lane_wdata,
  input  logic [BE_W-1:0]   lane_be,
  output amo_op_e           op_q,
  output logic              size4_q,
  output logic              hi_q,
  output logic [XLEN-1:0]   opnd_q,
  output logic [XLEN-1:0]   cmp_q,
  output logic [XLEN-1:0]   old_q,
  output logic              busy,
  output logic              done,
  output logic [XLEN-1:0]   done_old,
  output logic              done_written,
  output logic              fault,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-4:0] mem_addr,
  output logic [BE_W-1:0]   mem_be,
  output logic [XLEN-1:0]   mem_wdata
);
  amo_state_e state_q;
  logic       misaligned;

  assign misaligned = req_size4 ? (|req_addr[1:0]) : (|req_addr[2:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      op_q         <= AMO_XCHG;
      size4_q      <= 1'b0;
      hi_q         <= 1'b0;
      opnd_q       <= '0;
      cmp_q        <= '0;
      old_q        <= '0;
      busy         <= 1'b0;
      done         <= 1'b0;
      done_old     <= '0;
      done_written <= 1'b0;
      fault        <= 1'b0;
      mem_en       <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_be       <= '0;
      mem_wdata    <= '0;
    end else begin
      fault  <= 1'b0;
      done   <= 1'b0;
      mem_en <= 1'b0;
      mem_we <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (misaligned) begin
              fault <= 1'b1;
            end else begin
              op_q     <= amo_op_e'(req_op);
              size4_q  <= req_size4;
              hi_q     <= req_addr[2];
              opnd_q   <= req_opnd;
              cmp_q    <= req_cmp;
              busy     <= 1'b1;
              mem_en   <= 1'b1;
              mem_be   <= '1;
              mem_addr <= req_addr[ADDR_W-1:3];
              state_q  <= ST_RD;
            end
          end
        end
        ST_RD: state_q <= ST_WT;
        ST_WT: begin
          old_q   <= rd_ext;
          state_q <= ST_CMP;
        end
        ST_CMP: begin
          if (alu_wr) begin
            mem_en    <= 1'b1;
            mem_we    <= 1'b1;
            mem_be    <= lane_be;
            mem_wdata <= lane_wdata;
            state_q   <= ST_WR;
          end else begin
            done         <= 1'b1;
            done_old     <= old_q;
            done_written <= 1'b0;
            state_q      <= ST_DN;
          end
        end
        ST_WR: begin
          done         <= 1'b1;
          done_old     <= old_q;
          done_written <= 1'b1;
          state_q      <= ST_DN;
        end
        ST_DN: begin
          busy    <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  mem_in_lock_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> busy);

  // R7
  fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!busy && !mem_en && !done));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  write_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (done && done_written));

  // R2
  xchg_writes_chk: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == AMO_XCHG) |-> done_written);

  // R10
  reserved_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (done && (3'(op_q) >= 3'd6)) |-> !done_written);
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic              req_size4,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_opnd,
  input  logic [63:0]       req_cmp,
  output logic              busy,
  output logic              done,
  output logic [63:0]       done_old,
  output logic              done_written,
  output logic              fault,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-4:0] mem_addr,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata
);
  amo_op_e         op_q;
  logic            size4_q;
  logic            hi_q;
  logic [XLEN-1:0] opnd_q;
  logic [XLEN-1:0] cmp_q;
  logic [XLEN-1:0] old_q;
  logic [XLEN-1:0] rd_ext;
  logic [XLEN-1:0] alu_new;
  logic            alu_wr;
  logic [XLEN-1:0] lane_wdata;
  logic [BE_W-1:0] lane_be;

  amo_lane u_lane (
    .rd_word (mem_rdata),
    .hi      (hi_q),
    .size4   (size4_q),
    .new_val (alu_new),
    .old_ext (rd_ext),
    .wr_word (lane_wdata),
    .wr_be   (lane_be)
  );

  amo_alu u_alu (
    .op       (op_q),
    .size4    (size4_q),
    .old_val  (old_q),
    .opnd     (opnd_q),
    .cmp      (cmp_q),
    .new_val  (alu_new),
    .do_write (alu_wr)
  );

  amo_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_size4    (req_size4),
    .req_addr     (req_addr),
    .req_opnd     (req_opnd),
    .req_cmp      (req_cmp),
    .rd_ext       (rd_ext),
    .alu_new      (alu_new),
    .alu_wr       (alu_wr),
    .lane_wdata   (lane_wdata),
    .lane_be      (lane_be),
    .op_q         (op_q),
    .size4_q      (size4_q),
    .hi_q         (hi_q),
    .opnd_q       (opnd_q),
    .cmp_q        (cmp_q),
    .old_q        (old_q),
    .busy         (busy),
    .done         (done),
    .done_old     (done_old),
    .done_written (done_written),
    .fault        (fault),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .mem_wdata    (mem_wdata)
  );

  // R6
  lane_be_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ((mem_be == 8'hFF) || (mem_be == 8'h0F) || (mem_be == 8'hF0)));

  // R6
  half_store_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_be != 8'hFF) |-> (mem_wdata[63:32] == mem_wdata[31:0]));
endmodule

// File: tb/atomic_rmw_unit_bench.sv
module atomic_rmw_unit_bench;
  localparam int AW = 8;
  localparam int NW = 32;

  typedef struct packed {
    logic [2:0]  op;
    logic        w;
    logic [7:0]  addr;
    logic [63:0] opnd;
    logic [63:0] cmp;
    logic [63:0] init;
    logic [63:0] old;
    logic        wr;
    logic [63:0] fin;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 8'h08, 64'hAAAA_BBBB_CCCC_DDDD, 64'h0, 64'h1111_2222_3333_4444, 64'h1111_2222_3333_4444, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD},
    '{3'd1, 1'b0, 8'h10, 64'h9, 64'h5, 64'h5, 64'h5, 1'b1, 64'h9},
    '{3'd1, 1'b0, 8'h10, 64'h9, 64'h6, 64'h5, 64'h5, 1'b0, 64'h5},
    '{3'd1, 1'b1, 8'h14, 64'hDEAD_0000_CAFE_BABE, 64'h1234_5678_8000_0001, 64'h8000_0001_0000_0000, 64'hFFFF_FFFF_8000_0001, 1'b1, 64'hCAFE_BABE_0000_0000},
    '{3'd2, 1'b0, 8'h18, 64'h1, 64'h0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 1'b1, 64'h0000_0001_0000_0000},
    '{3'd2, 1'b1, 8'h20, 64'h2, 64'h0, 64'h1234_5678_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h1234_5678_0000_0001},
    '{3'd3, 1'b0, 8'h28, 64'hFFFF_FFFF_FFFF_FFFB, 64'h0, 64'h3, 64'h3, 1'b0, 64'h3},
    '{3'd3, 1'b0, 8'h28, 64'hFFFF_FFFF_FFFF_FFFB, 64'h0, 64'h5, 64'h5, 1'b1, 64'h0},
    '{3'd3, 1'b1, 8'h30, 64'h1, 64'h0, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF, 1'b0, 64'h0000_0000_7FFF_FFFF},
    '{3'd3, 1'b1, 8'h38, 64'hFFFF_FFFF_0000_0004, 64'h0, 64'h5555_5555_0000_0001, 64'h1, 1'b1, 64'h5555_5555_0000_0005},
    '{3'd4, 1'b0, 8'h40, 64'hFF00_FF00_FF00_FF00, 64'h0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hF0F0_F0F0_F0F0_F0F0, 1'b1, 64'hF000_F000_F000_F000},
    '{3'd5, 1'b1, 8'h4C, 64'h0000_0000_0000_0101, 64'h0, 64'h0000_1000_ABCD_0000, 64'h0000_0000_0000_1000, 1'b1, 64'h0000_1101_ABCD_0000},
    '{3'd0, 1'b1, 8'h54, 64'hFFFF_FFFF_0000_0042, 64'h0, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0123_4567, 1'b1, 64'h0000_0042_89AB_CDEF},
    '{3'd6, 1'b0, 8'h58, 64'h1234, 64'h0, 64'h77, 64'h77, 1'b0, 64'h77},
    '{3'd1, 1'b1, 8'h60, 64'h99, 64'h0000_0000_0000_0011, 64'hAAAA_AAAA_0000_0010, 64'h10, 1'b0, 64'hAAAA_AAAA_0000_0010}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = '0;
  logic          req_size4 = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0]   req_opnd = '0;
  logic [63:0]   req_cmp = '0;
  logic          busy, done, done_written, fault, mem_en, mem_we;
  logic [63:0]   done_old, mem_wdata;
  logic [63:0]   mem_rdata = '0;
  logic [AW-4:0] mem_addr;
  logic [7:0]    mem_be;

  logic [63:0]   mem [NW];
  logic          pre_en = 1'b0;
  logic [AW-4:0] pre_addr = '0;
  logic [63:0]   pre_data = '0;
  int            acc_cnt = 0;
  int            done_cnt = 0;
  int            checks = 0;
  int            errors = 0;

  always #4 clk = ~clk;

  atomic_rmw_unit #(.ADDR_W(AW)) u_atomic_rmw_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_size4(req_size4), .req_addr(req_addr), .req_opnd(req_opnd),
    .req_cmp(req_cmp), .busy(busy), .done(done), .done_old(done_old),
    .done_written(done_written), .fault(fault), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (pre_en) mem[pre_addr] <= pre_data;
    if (done) done_cnt <= done_cnt + 1;
    if (mem_en) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) begin
        for (int b = 0; b < 8; b++)
          if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr];
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [AW-4:0] a, input logic [63:0] d);
    @(negedge clk);
    pre_en = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input logic w, input logic [7:0] a,
                       input logic [63:0] b, input logic [63:0] c,
                       output logic [63:0] old, output logic wr, output int lat,
                       output logic busy_ok);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_size4 = w; req_addr = a;
    req_opnd = b; req_cmp = c;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    busy_ok = busy;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
      busy_ok = busy_ok & busy;
    end
    old = done_old;
    wr  = done_written;
    @(negedge clk);
  endtask

  function automatic string tag_of(input logic [2:0] op, input logic w);
    string t;
    case (op)
      3'd0: t = "R2";
      3'd1: t = "R3";
      3'd3: t = "R5";
      3'd6, 3'd7: t = "R10";
      default: t = "R4";
    endcase
    return w ? {t, "+R6"} : t;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] old;
    logic        wr;
    logic        bok;
    int          lat;
    int          acc0;
    int          dn0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", 64'(busy), 64'd0);
    chk("R11 done", 64'(done), 64'd0);
    chk("R11 fault", 64'(fault), 64'd0);
    chk("R11 mem_en", 64'(mem_en), 64'd0);

    for (int i = 0; i < NV; i++) begin
      preload(VECS[i].addr[7:3], VECS[i].init);
      issue(VECS[i].op, VECS[i].w, VECS[i].addr, VECS[i].opnd, VECS[i].cmp,
            old, wr, lat, bok);
      chk($sformatf("R1 v%0d old", i), old, VECS[i].old);
      chk($sformatf("%s v%0d written", tag_of(VECS[i].op, VECS[i].w), i), 64'(wr), 64'(VECS[i].wr));
      chk($sformatf("%s v%0d memory", tag_of(VECS[i].op, VECS[i].w), i), mem[VECS[i].addr[7:3]], VECS[i].fin);
      chk($sformatf("R9 v%0d latency", i), 64'(lat), VECS[i].wr ? 64'd5 : 64'd4);
      chk($sformatf("R8 v%0d busy held", i), 64'(bok), 64'd1);
      chk($sformatf("R8 v%0d busy released", i), 64'(busy), 64'd0);
    end

    // R7 misaligned 8-byte and 4-byte requests
    for (int k = 0; k < 2; k++) begin
      preload(5'd2, 64'h5A5A);
      acc0 = acc_cnt;
      dn0  = done_cnt;
      @(negedge clk);
      req_valid = 1'b1; req_op = 3'd0; req_opnd = 64'hFFFF;
      req_size4 = (k == 1); req_addr = (k == 1) ? 8'h12 : 8'h14;
      @(negedge clk);
      req_valid = 1'b0;
      chk($sformatf("R7 m%0d fault", k), 64'(fault), 64'd1);
      chk($sformatf("R7 m%0d busy", k), 64'(busy), 64'd0);
      @(negedge clk);
      chk($sformatf("R7 m%0d fault pulse", k), 64'(fault), 64'd0);
      repeat (6) @(negedge clk);
      chk($sformatf("R7 m%0d no access", k), 64'(acc_cnt - acc0), 64'd0);
      chk($sformatf("R7 m%0d no done", k), 64'(done_cnt - dn0), 64'd0);
      chk($sformatf("R7 m%0d memory", k), mem[2], 64'h5A5A);
    end

    // R8 request while busy is ignored
    preload(5'd3, 64'h33);
    preload(5'd4, 64'h44);
    dn0 = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd0; req_size4 = 1'b0; req_addr = 8'h18;
    req_opnd = 64'hAA;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 8'h20; req_opnd = 64'hBB;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 single done", 64'(done_cnt - dn0), 64'd1);
    chk("R8 first stored", mem[3], 64'hAA);
    chk("R8 second ignored", mem[4], 64'h44);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule